// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns the destination fields of an interrupt request into a mask of the agents that must receive it, for a system of eight agents. Every agent has three programmable fields: a physical identifier, a logical identifier, and a format model. The format model picks how the logical identifier is compared against the destination byte when logical addressing is used.

A request gives a destination byte, a physical/logical mode bit, a two-bit shorthand, a lowest-priority flag and the index of the sending agent. A non-zero shorthand replaces the decoded destination. The lowest-priority flag reduces the resolved set to one agent. The result is registered and shown for exactly one cycle with a valid strobe. Delivering the vector into each agent happens elsewhere.

Top module: `idr_resolver`

## Requirements
- R1: After reset, `tgt_valid` is 0 and `tgt_mask` is all zeros. Agent i holds physical ID i, logical ID 0x00 and format model 0xF (flat).
- R2: A cycle with `cfg_we` high writes the physical ID, logical ID and format of agent `cfg_agent`. A request sampled in that same cycle still resolves against the old values. Requests from the next cycle on use the new ones.
- R3: With `req_logical` = 0 and shorthand 0, destination 0xFF selects every agent. Any other value selects each agent whose physical ID equals it. If no agent matches, the mask is all zeros and `tgt_valid` still pulses.
- R4: With `req_logical` = 1 and shorthand 0, an agent whose format is 0xF (flat) is selected when the bitwise AND of the destination and its logical ID is non-zero.
- R5: With `req_logical` = 1 and shorthand 0, an agent whose format is 0x0 (cluster) is selected when destination bits [7:4] equal logical ID bits [7:4] and the AND of bits [3:0] of the two is non-zero.
- R6: In logical mode, an agent whose format is neither 0x0 nor 0xF is never selected. Physical mode ignores the format.
- R7: Shorthand 1 selects only the sender, shorthand 2 selects all agents, and shorthand 3 selects all agents except the sender. For shorthands 1 to 3, the destination byte and mode bit have no effect.
- R8: With `req_lowpri` = 1, only the lowest-indexed set bit of the resolved mask is kept. An empty resolved mask stays empty.
- R9: `tgt_valid` is high in exactly the cycle after each cycle with `req_valid` high, so back-to-back requests give back-to-back results. `tgt_mask` is all zeros whenever `tgt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one agent's configuration |
| cfg_agent | input | 3 | Agent index written by `cfg_we` |
| cfg_phys_id | input | 8 | New physical ID |
| cfg_log_id | input | 8 | New logical ID |
| cfg_fmt | input | 4 | New format model (0xF flat, 0x0 cluster) |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| req_lowpri | input | 1 | Keep only the lowest-indexed selected agent |
| req_sender | input | 3 | Index of the requesting agent |
| tgt_valid | output | 1 | One-cycle strobe for the resolved mask |
| tgt_mask | output | 8 | Resolved target agents, bit i for agent i |

## Verification
The checker's properties assume that `req_valid` is held low during reset and that `req_sender` is a valid agent index. Under those assumptions, every property that looks one cycle back reads values from a real request. The bench releases reset before it issues any request. It drives all inputs on the falling edge, and each request lasts one cycle, except for one deliberate back-to-back pair. Agent IDs are kept unique, so each physical-mode expectation names exactly one agent or none.

// File: rtl/idr_pkg.sv
package idr_pkg;

    localparam int ID_W  = 8;
    localparam int FMT_W = 4;

    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;
    localparam logic [ID_W-1:0]  DEST_BCAST  = 8'hFF;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [ID_W-1:0]  phys_id;
        logic [ID_W-1:0]  log_id;
        logic [FMT_W-1:0] fmt;
    } agent_cfg_t;

    // Logical-mode hit test for one agent's configuration.
    function automatic logic logical_hit(logic [ID_W-1:0] dest, agent_cfg_t c);
        logic hit;
        if (c.fmt == FMT_FLAT)
            hit = |(dest & c.log_id);
        else if (c.fmt == FMT_CLUSTER)
            hit = (dest[7:4] == c.log_id[7:4]) && (|(dest[3:0] & c.log_id[3:0]));
        else
            hit = 1'b0;
        return hit;
    endfunction

endpackage

// File: rtl/idr_agent_table.sv
module idr_agent_table
    import idr_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int AW = $clog2(N_AGENTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 idx,
    input  agent_cfg_t                    wdata,
    output agent_cfg_t [N_AGENTS-1:0]     cfg
);

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i].phys_id <= ID_W'(i);
                cfg[i].log_id  <= '0;
                cfg[i].fmt     <= FMT_FLAT;
            end else if (we && (idx == AW'(i))) begin
                cfg[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/idr_match.sv
module idr_match
    import idr_pkg::*;
#(
    parameter int N_AGENTS = 8
) (
    input  agent_cfg_t [N_AGENTS-1:0] cfg,
    input  logic [ID_W-1:0]           dest,
    input  logic                      logical,
    output logic [N_AGENTS-1:0]       hit
);

    logic bcast;
    assign bcast = (dest == DEST_BCAST);

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_cmp
        logic phys_hit;
        logic log_hit;
        assign phys_hit = bcast || (cfg[i].phys_id == dest);
        assign log_hit  = logical_hit(dest, cfg[i]);
        assign hit[i]   = logical ? log_hit : phys_hit;
    end

endmodule

// File: rtl/idr_select.sv
module idr_select
    import idr_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int AW = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  shorthand_e          sh,
    input  logic                lowpri,
    input  logic [AW-1:0]       sender,
    input  logic [N_AGENTS-1:0] decoded,
    output logic                out_valid,
    output logic [N_AGENTS-1:0] out_mask
);

    localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

    logic [N_AGENTS-1:0] self_bit;
    logic [N_AGENTS-1:0] chosen;
    logic [N_AGENTS-1:0] picked;

    assign self_bit = ONE << sender;

    always_comb begin
        unique case (sh)
            SH_SELF:   chosen = self_bit;
            SH_ALL:    chosen = '1;
            SH_OTHERS: chosen = ~self_bit;
            default:   chosen = decoded;
        endcase
    end

    // x & -x isolates the lowest set bit; zero stays zero.
    assign picked = lowpri ? (chosen & (~chosen + ONE)) : chosen;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else begin
            out_valid <= req;
            out_mask  <= req ? picked : '0;
        end
    end

endmodule

// File: rtl/idr_resolver.sv
module idr_resolver
    import idr_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int AW = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_agent,
    input  logic [7:0]          cfg_phys_id,
    input  logic [7:0]          cfg_log_id,
    input  logic [3:0]          cfg_fmt,
    input  logic                req_valid,
    input  logic [7:0]          req_dest,
    input  logic                req_logical,
    input  logic [1:0]          req_shorthand,
    input  logic                req_lowpri,
    input  logic [AW-1:0]       req_sender,
    output logic                tgt_valid,
    output logic [N_AGENTS-1:0] tgt_mask
);

    agent_cfg_t                wcfg;
    agent_cfg_t [N_AGENTS-1:0] table_q;
    logic [N_AGENTS-1:0]       decoded;

    assign wcfg = '{phys_id: cfg_phys_id, log_id: cfg_log_id, fmt: cfg_fmt};

    idr_agent_table #(.N_AGENTS(N_AGENTS)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_agent),
        .wdata (wcfg),
        .cfg   (table_q)
    );

    idr_match #(.N_AGENTS(N_AGENTS)) u_match (
        .cfg     (table_q),
        .dest    (req_dest),
        .logical (req_logical),
        .hit     (decoded)
    );

    idr_select #(.N_AGENTS(N_AGENTS)) u_select (
        .clk       (clk),
        .rst       (rst),
        .req       (req_valid),
        .sh        (shorthand_e'(req_shorthand)),
        .lowpri    (req_lowpri),
        .sender    (req_sender),
        .decoded   (decoded),
        .out_valid (tgt_valid),
        .out_mask  (tgt_mask)
    );

endmodule

// File: rtl/idr_resolver_chk.sv
module idr_resolver_chk #(
    parameter int N_AGENTS = 8,
    localparam int AW = $clog2(N_AGENTS)
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_shorthand,
    input logic                req_lowpri,
    input logic [AW-1:0]       req_sender,
    input logic                tgt_valid,
    input logic [N_AGENTS-1:0] tgt_mask
);

    localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

    // R9: a request yields a strobe on the next cycle
    a_r9_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> tgt_valid);

    // R9: no request, no strobe
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !tgt_valid);

    // R9: mask is quiet while the strobe is low
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !tgt_valid |-> (tgt_mask == '0));

    // R8: lowest-priority leaves at most one agent
    a_r8_single: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_lowpri) |=> $onehot0(tgt_mask));

    // R7: self shorthand targets the sender only
    a_r7_self: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shorthand == 2'd1) |=> (tgt_mask == (ONE << $past(req_sender))));

    // R7: all shorthand without lowest-priority
    a_r7_all: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shorthand == 2'd2 && !req_lowpri) |=> (&tgt_mask));

    // R7: all-but-self shorthand without lowest-priority
    a_r7_others: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shorthand == 2'd3 && !req_lowpri)
            |=> (tgt_mask == ~(ONE << $past(req_sender))));

endmodule

bind idr_resolver idr_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_shorthand (req_shorthand),
    .req_lowpri    (req_lowpri),
    .req_sender    (req_sender),
    .tgt_valid     (tgt_valid),
    .tgt_mask      (tgt_mask)
);

// File: tb/idr_resolver_bench.sv
`timescale 1ns/1ps
module idr_resolver_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_agent = '0;
    logic [7:0] cfg_phys_id = '0;
    logic [7:0] cfg_log_id = '0;
    logic [3:0] cfg_fmt = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_dest = '0;
    logic       req_logical = 1'b0;
    logic [1:0] req_shorthand = '0;
    logic       req_lowpri = 1'b0;
    logic [2:0] req_sender = '0;
    logic       tgt_valid;
    logic [7:0] tgt_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    idr_resolver u_idr_resolver (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_agent(cfg_agent), .cfg_phys_id(cfg_phys_id),
        .cfg_log_id(cfg_log_id), .cfg_fmt(cfg_fmt),
        .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
        .req_shorthand(req_shorthand), .req_lowpri(req_lowpri), .req_sender(req_sender),
        .tgt_valid(tgt_valid), .tgt_mask(tgt_mask)
    );

    task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic configure(int agent, logic [7:0] pid, logic [7:0] lid, logic [3:0] fmt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_agent = 3'(agent);
        cfg_phys_id = pid; cfg_log_id = lid; cfg_fmt = fmt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One request; expects {valid, mask} next cycle and quiet after it.
    task automatic send(string tag, logic [7:0] dest, logic logical, logic [1:0] sh,
                        logic lowpri, int sender, logic [7:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_dest = dest; req_logical = logical;
        req_shorthand = sh; req_lowpri = lowpri; req_sender = 3'(sender);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {tgt_valid, tgt_mask}, {1'b1, exp});
        @(negedge clk);
        check({tag, " R9 idle"}, {tgt_valid, tgt_mask}, 9'h000);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {tgt_valid, tgt_mask}, 9'h000);
        send("R1 default phys id", 8'h03, 1'b0, 2'd0, 1'b0, 0, 8'h08);
        send("R1 default logical id zero", 8'hFF, 1'b1, 2'd0, 1'b0, 0, 8'h00);
    endtask

    task automatic t_physical();
        send("R3 phys match", 8'h05, 1'b0, 2'd0, 1'b0, 0, 8'h20);
        send("R3 phys broadcast", 8'hFF, 1'b0, 2'd0, 1'b0, 0, 8'hFF);
        send("R3 phys no match", 8'h40, 1'b0, 2'd0, 1'b0, 0, 8'h00);
    endtask

    task automatic t_config();
        configure(2, 8'h40, 8'h00, 4'hF);
        send("R2 new phys id", 8'h40, 1'b0, 2'd0, 1'b0, 0, 8'h04);
        send("R2 old phys id gone", 8'h02, 1'b0, 2'd0, 1'b0, 0, 8'h00);
        // write and request in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_agent = 3'd6; cfg_phys_id = 8'h77; cfg_log_id = 8'h00; cfg_fmt = 4'hF;
        req_valid = 1'b1; req_dest = 8'h77; req_logical = 1'b0;
        req_shorthand = 2'd0; req_lowpri = 1'b0; req_sender = 3'd0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R2 same-cycle uses old", {tgt_valid, tgt_mask}, 9'h100);
        send("R2 next cycle uses new", 8'h77, 1'b0, 2'd0, 1'b0, 0, 8'h40);
    endtask

    task automatic t_flat();
        for (int i = 0; i < 8; i++)
            configure(i, (i == 2) ? 8'h40 : (i == 6) ? 8'h77 : 8'(i), 8'(1 << i), 4'hF);
        send("R4 flat two agents", 8'h81, 1'b1, 2'd0, 1'b0, 0, 8'h81);
        send("R4 flat zero dest", 8'h00, 1'b1, 2'd0, 1'b0, 0, 8'h00);
    endtask

    task automatic t_cluster();
        configure(1, 8'h01, 8'h23, 4'h0);
        configure(4, 8'h04, 8'h21, 4'h0);
        configure(5, 8'h05, 8'h31, 4'h0);
        send("R5 cluster mixed", 8'h21, 1'b1, 2'd0, 1'b0, 0, 8'h13);
        send("R5 cluster member mask", 8'h22, 1'b1, 2'd0, 1'b0, 0, 8'h02);
    endtask

    task automatic t_other_fmt();
        configure(3, 8'h03, 8'hFF, 4'h5);
        send("R6 odd format skipped", 8'h08, 1'b1, 2'd0, 1'b0, 0, 8'h00);
        send("R6 physical ignores format", 8'h03, 1'b0, 2'd0, 1'b0, 0, 8'h08);
    endtask

    task automatic t_shorthand();
        send("R7 self", 8'hFF, 1'b0, 2'd1, 1'b0, 6, 8'h40);
        send("R7 all ignores dest", 8'h00, 1'b1, 2'd2, 1'b0, 3, 8'hFF);
        send("R7 others sender 0", 8'h05, 1'b0, 2'd3, 1'b0, 0, 8'hFE);
        send("R7 others sender 7", 8'h05, 1'b0, 2'd3, 1'b0, 7, 8'h7F);
    endtask

    task automatic t_lowpri();
        send("R8 lowpri broadcast", 8'hFF, 1'b0, 2'd0, 1'b1, 0, 8'h01);
        send("R8 lowpri others", 8'h00, 1'b0, 2'd3, 1'b1, 0, 8'h02);
        send("R8 lowpri logical", 8'h21, 1'b1, 2'd0, 1'b1, 0, 8'h01);
        send("R8 lowpri flat high", 8'hC0, 1'b1, 2'd0, 1'b1, 0, 8'h40);
        send("R8 lowpri empty", 8'h99, 1'b0, 2'd0, 1'b1, 0, 8'h00);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_dest = 8'h05; req_logical = 1'b0;
        req_shorthand = 2'd0; req_lowpri = 1'b0; req_sender = 3'd0;
        @(negedge clk);
        check("R9 first of pair", {tgt_valid, tgt_mask}, 9'h120);
        req_dest = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second of pair", {tgt_valid, tgt_mask}, 9'h1FF);
        @(negedge clk);
        check("R9 after pair", {tgt_valid, tgt_mask}, 9'h000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_physical();
        t_config();
        t_flat();
        t_cluster();
        t_other_fmt();
        t_shorthand();
        t_lowpri();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule